// File: doc/BRIEF.md
# Word-Input CRC-32 Engine with Byte-Order and Bit-Order Conditioning

This block accumulates a CRC-32 over a stream of 32-bit words, taking one word on each cycle that the valid strobe is high. Before a word is folded into the running checksum, a conditioning stage reorders it. A 2-bit order code picks one of four byte arrangements. A separate enable then mirrors the bit order inside every byte. The two controls are independent, so all eight combinations can be used.

The update divides by the generator 0x04C11DB7. The conditioned word is consumed most significant bit first, as 32 serial shift-register steps collapsed into one cycle of logic. A seed strobe loads any 32-bit start value into the checksum register. The register value is presented directly on the result port. No final inversion or reflection is applied, so the caller does any post-processing it needs.

Top module: `crc_word_engine`

## Requirements
- R1: While `rst` is high at a rising clock edge, the checksum register takes the value of the parameter `RESET_VALUE` (default 0xFFFFFFFF), and `crc_out` shows it after that edge.
- R2: With `order_sel` = 0 the word is used unchanged. Viewing the input as lanes {L3,L2,L1,L0} with L3 in bits 31:24, the conditioned word is {L3,L2,L1,L0}.
- R3: With `order_sel` = 1 the two bytes inside each halfword trade places, giving {L2,L3,L0,L1}.
- R4: With `order_sel` = 2 the two halfwords trade places and the bytes inside each keep their order, giving {L1,L0,L3,L2}.
- R5: With `order_sel` = 3 the word is fully byte-reversed, giving {L0,L1,L2,L3}.
- R6: When `bit_rev` is 1, the bit order inside each byte is mirrored after the byte reordering (bit 7 of a byte becomes bit 0), and the byte positions chosen by `order_sel` are kept. This holds for every `order_sel` value.
- R7: On a rising edge with `data_valid` = 1 and `seed_load` = 0, the register becomes the CRC-32 (generator 0x04C11DB7, MSB-first, one step per bit for all 32 conditioned bits) of the old value and the conditioned word. `crc_out` shows the result one cycle later, with no final XOR and no reflection.
- R8: On a rising edge with `seed_load` = 1, the register loads `seed_value`, whatever `data_valid` is.
- R9: On a rising edge with `rst`, `seed_load` and `data_valid` all 0, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_value` into the checksum register |
| seed_value | input | 32 | Start value for a new checksum |
| order_sel | input | 2 | Byte arrangement code, 0 to 3 |
| bit_rev | input | 1 | Mirror the bits inside each byte after reordering |
| data_valid | input | 1 | `data_word` is to be folded in this cycle |
| data_word | input | 32 | Input data word |
| crc_out | output | 32 | Current checksum register value |

## Verification
On every cycle the assertions check four things. Seeding wins over data and the register holds when idle. The conditioned word keeps the input's population count and is an exact 32-bit mirror in the full-reverse, bit-reversed mode. An all-zero state folded with an all-zero word stays zero. Only the bench's scenarios can show that each order code places the right lane in the right position and that the checksum arithmetic is correct. For this the bench sweeps all eight control combinations with long pseudo-random word streams. It compares every result against a bit-serial model fed with lanes it arranges itself, and it includes seed/data collisions and idle gaps.

// File: rtl/crc_word_pkg.sv
package crc_word_pkg;

    localparam int WORD_W     = 32;
    localparam int CRC_W      = 32;
    localparam int BYTE_W     = 8;
    localparam int NUM_LANES  = WORD_W / BYTE_W;
    localparam int LANE_SEL_W = $clog2(NUM_LANES);

    localparam logic [CRC_W-1:0] CRC32_GEN = 32'h04C1_1DB7;

    typedef enum logic [LANE_SEL_W-1:0] {
        ORD_KEEP      = 2'd0,
        ORD_PAIR_SWAP = 2'd1,
        ORD_HALF_SWAP = 2'd2,
        ORD_FULL_REV  = 2'd3
    } order_e;

    typedef struct packed {
        order_e order;
        logic   bit_rev;
    } cond_ctrl_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_SEED,
        ACT_FOLD
    } reg_action_e;

    function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] fold_word(
        input logic [CRC_W-1:0]  state,
        input logic [WORD_W-1:0] word,
        input logic [CRC_W-1:0]  gen
    );
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = state;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ word[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? gen : '0);
        end
        return acc;
    endfunction

endpackage

// File: rtl/crc_word_cond.sv
module crc_word_cond
    import crc_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cond_ctrl_t        ctrl,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    logic [BYTE_W-1:0] lane_in  [NUM_LANES];
    logic [BYTE_W-1:0] lane_mov [NUM_LANES];

    genvar k;
    generate
        for (k = 0; k < NUM_LANES; k++) begin : g_lane
            logic [LANE_SEL_W-1:0] src_idx;

            assign lane_in[k] = din[k*BYTE_W +: BYTE_W];

            // Every order code maps output lane k to input lane k XOR code.
            assign src_idx     = LANE_SEL_W'(k) ^ ctrl.order;
            assign lane_mov[k] = lane_in[src_idx];

            assign dout[k*BYTE_W +: BYTE_W] =
                ctrl.bit_rev ? mirror_byte(lane_mov[k]) : lane_mov[k];
        end
    endgenerate

    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
        $countones(dout) == $countones(din)); // R6

    AST_FULL_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (ctrl.order == ORD_FULL_REV && ctrl.bit_rev) |-> (dout == {<<{din}})); // R5

    AST_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.order == ORD_KEEP && !ctrl.bit_rev) |-> (dout == din)); // R2

endmodule

// File: rtl/crc_word_fold.sv
module crc_word_fold
    import crc_word_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC32_GEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [CRC_W-1:0]  crc_next
);

    always_comb begin
        crc_next = fold_word(crc_in, word_in, POLY);
    end

    AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (crc_in == '0 && word_in == '0) |-> (crc_next == '0)); // R7

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg
    import crc_word_pkg::*;
#(
    parameter logic [CRC_W-1:0] RESET_VALUE = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_load,
    input  logic [CRC_W-1:0] seed_value,
    input  logic             upd_en,
    input  logic [CRC_W-1:0] next_val,
    output logic [CRC_W-1:0] q
);

    reg_action_e action;

    always_comb begin
        if (seed_load)   action = ACT_SEED;
        else if (upd_en) action = ACT_FOLD;
        else             action = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VALUE;
        end else begin
            unique case (action)
                ACT_SEED: q <= seed_value;
                ACT_FOLD: q <= next_val;
                default:  q <= q;
            endcase
        end
    end

    AST_SEED_WINS: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (q == $past(seed_value))); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !upd_en) |=> $stable(q)); // R9

    AST_FOLD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !seed_load) |=> (q == $past(next_val))); // R7

endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine
    import crc_word_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY        = CRC32_GEN,
    parameter logic [CRC_W-1:0] RESET_VALUE = 32'hFFFF_FFFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  seed_load,
    input  logic [CRC_W-1:0]      seed_value,
    input  logic [LANE_SEL_W-1:0] order_sel,
    input  logic                  bit_rev,
    input  logic                  data_valid,
    input  logic [WORD_W-1:0]     data_word,
    output logic [CRC_W-1:0]      crc_out
);

    cond_ctrl_t        ctrl;
    logic [WORD_W-1:0] cond_word;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_nx;

    assign ctrl.order   = order_e'(order_sel);
    assign ctrl.bit_rev = bit_rev;

    crc_word_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .din  (data_word),
        .dout (cond_word)
    );

    crc_word_fold #(.POLY(POLY)) u_fold (
        .clk      (clk),
        .rst      (rst),
        .crc_in   (crc_q),
        .word_in  (cond_word),
        .crc_next (crc_nx)
    );

    crc_state_reg #(.RESET_VALUE(RESET_VALUE)) u_state (
        .clk        (clk),
        .rst        (rst),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .upd_en     (data_valid),
        .next_val   (crc_nx),
        .q          (crc_q)
    );

    assign crc_out = crc_q;

    AST_RESET_VALUE: assert property (@(posedge clk)
        $past(rst) |-> (crc_out == RESET_VALUE)); // R1

endmodule

// File: tb/crc_word_engine_tb_top.sv
module crc_word_engine_tb_top;

    localparam logic [31:0] GEN  = 32'h04C1_1DB7;
    localparam logic [31:0] RVAL = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic [1:0]  order_sel = '0;
    logic        bit_rev = 1'b0;
    logic        data_valid = 1'b0;
    logic [31:0] data_word = '0;
    logic [31:0] crc_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model;
    logic [31:0] prng = 32'h1234_5678;

    always #2 clk = ~clk;

    crc_word_engine dut_i (
        .clk        (clk),
        .rst        (rst),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .order_sel  (order_sel),
        .bit_rev    (bit_rev),
        .data_valid (data_valid),
        .data_word  (data_word),
        .crc_out    (crc_out)
    );

    function automatic logic [31:0] arrange(input logic [31:0] w, input logic [1:0] code,
                                            input logic br);
        logic [7:0]  b0, b1, b2, b3;
        logic [31:0] r;
        b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
        case (code)
            2'd0:    r = {b3, b2, b1, b0};
            2'd1:    r = {b2, b3, b0, b1};
            2'd2:    r = {b1, b0, b3, b2};
            default: r = {b0, b1, b2, b3};
        endcase
        if (br) begin
            logic [31:0] m;
            for (int p = 0; p < 4; p++)
                for (int q = 0; q < 8; q++)
                    m[p*8 + q] = r[p*8 + 7 - q];
            r = m;
        end
        return r;
    endfunction

    function automatic logic [31:0] serial_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] s;
        s = c;
        for (int i = 31; i >= 0; i--) begin
            if (s[31] ^ d[i]) s = (s << 1) ^ GEN;
            else              s = s << 1;
        end
        return s;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Inputs change at a falling edge; the next falling edge follows the capturing rising edge.
    task automatic tick();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        string tag;
        @(negedge clk);
        rst = 1'b1;
        data_valid = 1'b1;
        data_word  = 32'hDEAD_BEEF;
        tick();
        tick();
        check("R1 reset value", crc_out, RVAL);

        // R8: seed beats a data word in the same cycle
        rst = 1'b0;
        seed_load  = 1'b1;
        seed_value = 32'hA5A5_0F0F;
        data_valid = 1'b1;
        tick();
        check("R8 seed priority", crc_out, 32'hA5A5_0F0F);
        model = 32'hA5A5_0F0F;

        // R9: idle cycles hold
        seed_load  = 1'b0;
        data_valid = 1'b0;
        data_word  = 32'h0123_4567;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R9 hold idle", crc_out, model);
        end

        // R7: a single known-pattern fold
        order_sel  = 2'd0;
        bit_rev    = 1'b0;
        data_valid = 1'b1;
        data_word  = 32'h8000_0000;
        tick();
        model = serial_crc(model, 32'h8000_0000);
        check("R7 single fold", crc_out, model);

        // R2..R6, R7: sweep all eight control combinations
        for (int combo = 0; combo < 8; combo++) begin
            logic [1:0] code;
            logic       br;
            code = combo[1:0];
            br   = combo[2];
            case (code)
                2'd0: tag = br ? "R2/R6 order0 mirrored" : "R2 order0";
                2'd1: tag = br ? "R3/R6 order1 mirrored" : "R3 order1";
                2'd2: tag = br ? "R4/R6 order2 mirrored" : "R4 order2";
                default: tag = br ? "R5/R6 order3 mirrored" : "R5 order3";
            endcase

            prng       = next_rand(prng);
            seed_load  = 1'b1;
            seed_value = prng;
            data_valid = 1'b0;
            tick();
            model = prng;
            check("R8 seed load", crc_out, model);

            seed_load = 1'b0;
            order_sel = code;
            bit_rev   = br;
            for (int n = 0; n < 40; n++) begin
                prng = next_rand(prng);
                data_word  = prng;
                data_valid = (n % 9 != 4);
                tick();
                if (data_valid) begin
                    model = serial_crc(model, arrange(prng, code, br));
                    check(tag, crc_out, model);
                end else begin
                    check("R9 hold gap", crc_out, model);
                end
            end
        end

        // R6 independence: same word, byte-distinct, every combination from a zero seed
        for (int combo = 0; combo < 8; combo++) begin
            seed_load  = 1'b1;
            seed_value = '0;
            data_valid = 1'b0;
            tick();
            seed_load  = 1'b0;
            order_sel  = combo[1:0];
            bit_rev    = combo[2];
            data_valid = 1'b1;
            data_word  = 32'h1E2D_3C4B;
            tick();
            check("R6 combo fold", crc_out,
                  serial_crc(32'h0, arrange(32'h1E2D_3C4B, combo[1:0], combo[2])));
        end

        // R1: reset in the middle of a stream
        data_valid = 1'b1;
        rst = 1'b1;
        tick();
        check("R1 reset mid-stream", crc_out, RVAL);
        rst = 1'b0;
        data_valid = 1'b0;
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule